// File: doc/BRIEF.md
# Instruction-Pair Fetch Sequencer

This block is the fetch and decode controller of an accumulator machine whose memory packs two instructions into every 40-bit word. It reads one word through a request/valid memory port and latches it in a memory buffer register. It presents the left-hand instruction first and keeps the right-hand one in an instruction buffer register. The right-hand instruction is then issued from that buffer without a second memory access. The program counter therefore points at an instruction pair, not at a single instruction.

For each instruction the sequencer places the opcode in the instruction register output and the address field in the memory address register output. It then raises `exec_valid` and waits for the execute phase to answer with `exec_done`. Along with `exec_done` the execute phase may report a taken branch. In that case the buffered instruction is discarded and fetching resumes at the target word, at its left-hand or right-hand half as requested. A fetch address beyond the last valid word stops the sequencer with a sticky error.

Top module: `pair_fetch_seq`

## Requirements
- R1: After reset `mem_req`, `exec_valid` and `halted` are 0, and the first memory read is made at address 0.
- R2: A word holds the left-hand instruction in bits [39:20] and the right-hand instruction in bits [19:0]. Within each instruction the opcode is the upper 8 bits and the address field is the lower 12 bits.
- R3: After a word is read, the left-hand instruction is presented first on `ir_op`/`mar_addr` with `exec_valid` high. The outputs stay stable until `exec_done` is seen.
- R4: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is sampled high. The word captured is the one on `mem_rdata` in that cycle.
- R5: When a left-hand instruction completes with no branch, the right-hand instruction of the same word is presented next, with no new memory request.
- R6: The program counter advances by one only after the right-hand instruction has been taken. The read that follows is at the previous address plus one.
- R7: A taken branch on `exec_done` discards the buffered instruction, and the next read is at `br_target`. With `br_right` = 0 execution resumes at the left-hand instruction of the target word. With `br_right` = 1 it resumes at the right-hand instruction, and the read after that is at target plus one.
- R8: No read is ever requested above address 999. When a fetch would need one, `halted` rises and stays high until reset, with `mem_req` and `exec_valid` held at 0.
- R9: `exec_done` and the branch inputs are ignored outside the execute phase, including while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 12 | Word address of the read (program counter) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 40 | Read data word |
| ir_op | output | 8 | Opcode of the current instruction |
| mar_addr | output | 12 | Address field of the current instruction |
| exec_valid | output | 1 | Execute phase active for the presented instruction |
| exec_done | input | 1 | Execute phase finished |
| br_taken | input | 1 | Branch taken, qualified by `exec_done` |
| br_target | input | 12 | Branch target word address |
| br_right | input | 1 | Resume at right-hand (1) or left-hand (0) instruction of the target |
| halted | output | 1 | Sticky address-range error; sequencer stopped |

## Verification
The assertions check several properties on every cycle. A pending request holds its address, and the presented instruction stays stable until `exec_done`. A valid buffer never coexists with a memory request. No request goes out above the address limit, and the halt is sticky. Only the bench scenarios can show the data-dependent behaviour. These are the left-before-right order and the exact field split of a word. They also include the program counter advancing only after the right-hand slot, and the resume point after a branch to either half. Finally they show that a stray `exec_done` during a slow read changes nothing.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [2:0] {
      ST_SEL  = 3'd0,
      ST_RD   = 3'd1,
      ST_LOAD = 3'd2,
      ST_EXEC = 3'd3,
      ST_HALT = 3'd4
   } pfs_state_e;

   typedef enum logic [1:0] {
      SRC_IBR   = 2'd0,
      SRC_MBR_L = 2'd1,
      SRC_MBR_R = 2'd2
   } pfs_src_e;
endpackage

// File: rtl/pfs_range_chk.sv
module pfs_range_chk #(
   parameter int ADDR_W   = 12,
   parameter int MAX_ADDR = 999,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              bad
);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MAX_ADDR);

   generate
      if (CHECK_EN) begin : g_cmp
         assign bad = (addr > LIMIT);
      end else begin : g_off
         assign bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pfs_word_buf.sv
module pfs_word_buf #(
   parameter int INSTR_W = 20,
   parameter int SLOTS   = 2,
   localparam int WORD_W = INSTR_W * SLOTS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_mbr,
   input  logic [WORD_W-1:0]  mbr_in,
   input  logic               hold_ibr,
   input  logic               drop_ibr,
   output logic [INSTR_W-1:0] left_instr,
   output logic [INSTR_W-1:0] right_instr,
   output logic [INSTR_W-1:0] ibr_instr,
   output logic               ibr_valid
);
   logic [WORD_W-1:0]  mbr_q;
   logic [INSTR_W-1:0] slot [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mbr_q <= '0;
      else if (cap_mbr) mbr_q <= mbr_in;
   end

   // slot 0 is the low half (right-hand), the top slot is the left-hand one
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot[s] = mbr_q[s*INSTR_W +: INSTR_W];
   end

   assign left_instr  = slot[SLOTS-1];
   assign right_instr = slot[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibr_instr <= '0;
         ibr_valid <= 1'b0;
      end else if (drop_ibr) begin
         ibr_valid <= 1'b0;
      end else if (hold_ibr) begin
         ibr_instr <= right_instr;
         ibr_valid <= 1'b1;
      end
   end

   a_r5_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ibr && !drop_ibr |=> ibr_valid && ibr_instr == $past(right_instr));
endmodule

// File: rtl/pfs_dec_regs.sv
module pfs_dec_regs import pfs_pkg::*; #(
   parameter int OP_W   = 8,
   parameter int ADDR_W = 12,
   localparam int INSTR_W = OP_W + ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  pfs_src_e           src,
   input  logic [INSTR_W-1:0] ibr_instr,
   input  logic [INSTR_W-1:0] left_instr,
   input  logic [INSTR_W-1:0] right_instr,
   output logic [OP_W-1:0]    ir_q,
   output logic [ADDR_W-1:0]  mar_q
);
   logic [INSTR_W-1:0] pick;

   always_comb begin
      unique case (src)
         SRC_MBR_L: pick = left_instr;
         SRC_MBR_R: pick = right_instr;
         default:   pick = ibr_instr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q  <= '0;
         mar_q <= '0;
      end else if (load) begin
         ir_q  <= pick[INSTR_W-1 -: OP_W];
         mar_q <= pick[ADDR_W-1:0];
      end
   end
endmodule

// File: rtl/pfs_seq_fsm.sv
module pfs_seq_fsm import pfs_pkg::*; #(
   parameter int ADDR_W   = 12,
   parameter int MAX_ADDR = 999,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_rvalid,
   input  logic              exec_done,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              br_right,
   input  logic              ibr_valid,
   input  logic              addr_bad,
   output logic [ADDR_W-1:0] pc,
   output logic              mem_req,
   output logic              cap_mbr,
   output logic              load_ir,
   output pfs_src_e          load_src,
   output logic              hold_ibr,
   output logic              drop_ibr,
   output logic              exec_valid,
   output logic              halted
);
   pfs_state_e state, nxt;
   logic       start_right;
   logic       pc_inc, pc_load, sr_clr;

   always_comb begin
      nxt      = state;
      mem_req  = 1'b0;
      cap_mbr  = 1'b0;
      load_ir  = 1'b0;
      load_src = SRC_IBR;
      hold_ibr = 1'b0;
      drop_ibr = 1'b0;
      pc_inc   = 1'b0;
      pc_load  = 1'b0;
      sr_clr   = 1'b0;
      unique case (state)
         ST_SEL: begin
            if (ibr_valid) begin
               load_ir  = 1'b1;
               drop_ibr = 1'b1;
               pc_inc   = 1'b1;
               nxt      = ST_EXEC;
            end else if (addr_bad) begin
               nxt = ST_HALT;
            end else begin
               nxt = ST_RD;
            end
         end
         ST_RD: begin
            mem_req = 1'b1;
            if (mem_rvalid) begin
               cap_mbr = 1'b1;
               nxt     = ST_LOAD;
            end
         end
         ST_LOAD: begin
            load_ir = 1'b1;
            if (start_right) begin
               load_src = SRC_MBR_R;
               pc_inc   = 1'b1;
               sr_clr   = 1'b1;
            end else begin
               load_src = SRC_MBR_L;
               hold_ibr = 1'b1;
            end
            nxt = ST_EXEC;
         end
         ST_EXEC: begin
            if (exec_done) begin
               if (br_taken) begin
                  pc_load  = 1'b1;
                  drop_ibr = 1'b1;
               end
               nxt = ST_SEL;
            end
         end
         default: nxt = ST_HALT;
      endcase
   end

   assign exec_valid = (state == ST_EXEC);
   assign halted     = (state == ST_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_SEL;
         pc          <= '0;
         start_right <= 1'b0;
      end else begin
         state <= nxt;
         if (pc_load)     pc <= br_target;
         else if (pc_inc) pc <= pc + 1'b1;
         if (pc_load)     start_right <= br_right;
         else if (sr_clr) start_right <= 1'b0;
      end
   end

   a_r4_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(pc));

   a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && !mem_req && !exec_valid);

   generate
      if (CHECK_EN) begin : g_rng_chk
         a_r8_req_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |-> pc <= ADDR_W'(MAX_ADDR));
      end
   endgenerate
endmodule

// File: rtl/pair_fetch_seq.sv
module pair_fetch_seq import pfs_pkg::*; #(
   parameter int OP_W     = 8,
   parameter int ADDR_W   = 12,
   parameter int SLOTS    = 2,
   parameter int WORD_W   = 40,
   parameter int MAX_ADDR = 999,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [OP_W-1:0]   ir_op,
   output logic [ADDR_W-1:0] mar_addr,
   output logic              exec_valid,
   input  logic              exec_done,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              br_right,
   output logic              halted
);
   localparam int INSTR_W = OP_W + ADDR_W;

   initial begin
      a_cfg_word: assert (WORD_W == INSTR_W * SLOTS)
         else $error("word width must hold exactly the instruction slots");
      a_cfg_slots: assert (SLOTS == 2)
         else $error("sequencer issues a left and a right slot only");
      a_cfg_limit: assert (MAX_ADDR < (1 << ADDR_W))
         else $error("address limit exceeds address width");
   end

   logic               cap_mbr, load_ir, hold_ibr, drop_ibr, ibr_valid, addr_bad;
   pfs_src_e           load_src;
   logic [INSTR_W-1:0] left_instr, right_instr, ibr_instr;
   logic [ADDR_W-1:0]  pc;

   pfs_seq_fsm #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR), .CHECK_EN(CHECK_EN)) fsm_i (
      .clk(clk), .rst_n(rst_n), .mem_rvalid(mem_rvalid), .exec_done(exec_done),
      .br_taken(br_taken), .br_target(br_target), .br_right(br_right),
      .ibr_valid(ibr_valid), .addr_bad(addr_bad), .pc(pc), .mem_req(mem_req),
      .cap_mbr(cap_mbr), .load_ir(load_ir), .load_src(load_src),
      .hold_ibr(hold_ibr), .drop_ibr(drop_ibr), .exec_valid(exec_valid),
      .halted(halted)
   );

   pfs_range_chk #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR), .CHECK_EN(CHECK_EN)) rng_i (
      .addr(pc), .bad(addr_bad)
   );

   pfs_word_buf #(.INSTR_W(INSTR_W), .SLOTS(SLOTS)) buf_i (
      .clk(clk), .rst_n(rst_n), .cap_mbr(cap_mbr), .mbr_in(mem_rdata),
      .hold_ibr(hold_ibr), .drop_ibr(drop_ibr), .left_instr(left_instr),
      .right_instr(right_instr), .ibr_instr(ibr_instr), .ibr_valid(ibr_valid)
   );

   pfs_dec_regs #(.OP_W(OP_W), .ADDR_W(ADDR_W)) dec_i (
      .clk(clk), .rst_n(rst_n), .load(load_ir), .src(load_src),
      .ibr_instr(ibr_instr), .left_instr(left_instr), .right_instr(right_instr),
      .ir_q(ir_op), .mar_q(mar_addr)
   );

   assign mem_addr = pc;

   a_r3_instr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid && !exec_done |=> exec_valid && $stable(ir_op) && $stable(mar_addr));

   a_r5_no_req_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
      ibr_valid |-> !mem_req);

   a_r9_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> !exec_valid);
endmodule

// File: tb/pair_fetch_seq_tb_top.sv
module pair_fetch_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req, exec_valid, halted;
   logic [11:0] mem_addr, mar_addr;
   logic        mem_rvalid = 1'b0;
   logic [39:0] mem_rdata = '0;
   logic [7:0]  ir_op;
   logic        exec_done = 1'b0, br_taken = 1'b0, br_right = 1'b0;
   logic [11:0] br_target = '0;

   int errors = 0, checks = 0;
   int lat = 0, cnt = 0, rd_count = 0, req_cycles = 0;
   int last_rd = -1;
   int cyc = 0;

   always #4 clk = ~clk;  // 125 MHz

   pair_fetch_seq dut_i (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ir_op(ir_op),
      .mar_addr(mar_addr), .exec_valid(exec_valid), .exec_done(exec_done),
      .br_taken(br_taken), .br_target(br_target), .br_right(br_right),
      .halted(halted)
   );

   // program image: left = {a*3+1, a}, right = {a*3+2, a+500}
   function automatic logic [7:0] l_op(int a);  return 8'(a*3+1); endfunction
   function automatic logic [7:0] r_op(int a);  return 8'(a*3+2); endfunction
   function automatic logic [11:0] l_ad(int a); return 12'(a); endfunction
   function automatic logic [11:0] r_ad(int a); return 12'(a+500); endfunction

   always @(negedge clk) begin
      if (mem_req && !mem_rvalid) begin
         req_cycles++;
         if (cnt >= lat) begin
            mem_rvalid = 1'b1;
            mem_rdata  = {l_op(int'(mem_addr)), l_ad(int'(mem_addr)),
                          r_op(int'(mem_addr)), r_ad(int'(mem_addr))};
            rd_count++;
            last_rd = int'(mem_addr);
            cnt = 0;
         end else cnt++;
      end else begin
         mem_rvalid = 1'b0;
         mem_rdata  = '0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; lat = 0; exec_done = 0; br_taken = 0; br_right = 0; br_target = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_exec();
      int t = 0;
      @(negedge clk);
      while (!exec_valid && t < 300) begin
         @(negedge clk);
         t++;
      end
      chk(exec_valid, "exec_valid wait", int'(exec_valid), 1);
   endtask

   task automatic finish(input bit br, input int tgt, input bit right);
      exec_done = 1'b1; br_taken = br; br_target = 12'(tgt); br_right = right;
      @(negedge clk);
      exec_done = 1'b0; br_taken = 1'b0; br_right = 1'b0;
   endtask

   task automatic expect_instr(input string req, input logic [7:0] op, input logic [11:0] ad);
      wait_exec();
      chk(ir_op == op, req, int'(ir_op), int'(op));
      chk(mar_addr == ad, req, int'(mar_addr), int'(ad));
   endtask

   task automatic t_reset();
      do_reset();
      chk(mem_req == 1'b0, "R1 mem_req after reset", int'(mem_req), 0);
      chk(exec_valid == 1'b0, "R1 exec_valid after reset", int'(exec_valid), 0);
      chk(halted == 1'b0, "R1 halted after reset", int'(halted), 0);
      @(negedge clk);
      chk(mem_req && mem_addr == 0, "R1 first read at 0", int'(mem_addr), 0);
   endtask

   task automatic t_pair_order();
      int rc;
      expect_instr("R2 R3 left of word 0", l_op(0), l_ad(0));
      repeat (3) @(negedge clk);
      chk(exec_valid && ir_op == l_op(0), "R3 held until done", int'(ir_op), int'(l_op(0)));
      rc = rd_count;
      finish(1'b0, 0, 1'b0);
      expect_instr("R2 R5 right of word 0", r_op(0), r_ad(0));
      chk(rd_count == rc, "R5 no read for right slot", rd_count, rc);
      finish(1'b0, 0, 1'b0);
      expect_instr("R6 left of word 1", l_op(1), l_ad(1));
      chk(last_rd == 1, "R6 pc advanced", last_rd, 1);
      finish(1'b0, 0, 1'b0);
      expect_instr("R5 right of word 1", r_op(1), r_ad(1));
   endtask

   task automatic t_slow_read();
      lat = 4;
      req_cycles = 0;
      finish(1'b0, 0, 1'b0);
      repeat (2) @(negedge clk);
      chk(mem_req == 1'b1, "R4 read pending", int'(mem_req), 1);
      // r9_: stray done and branch while the read is outstanding
      exec_done = 1'b1; br_taken = 1'b1; br_target = 12'd30; br_right = 1'b1;
      @(negedge clk);
      exec_done = 1'b0; br_taken = 1'b0; br_right = 1'b0;
      expect_instr("R9 R4 left of word 2 despite stray done", l_op(2), l_ad(2));
      chk(last_rd == 2, "R9 read address unchanged", last_rd, 2);
      chk(req_cycles == 5, "R4 request held over latency", req_cycles, 5);
      lat = 1;
   endtask

   task automatic t_branch();
      int rc = rd_count;
      finish(1'b1, 40, 1'b0);
      expect_instr("R7 left of target 40", l_op(40), l_ad(40));
      chk(rd_count == rc + 1 && last_rd == 40, "R7 read at target", last_rd, 40);
      finish(1'b0, 0, 1'b0);
      expect_instr("R7 right of 40 from buffer", r_op(40), r_ad(40));
      finish(1'b1, 60, 1'b1);
      expect_instr("R7 right of target 60", r_op(60), r_ad(60));
      chk(last_rd == 60, "R7 read at 60", last_rd, 60);
      finish(1'b0, 0, 1'b0);
      expect_instr("R7 R6 left of 61 after right resume", l_op(61), l_ad(61));
      chk(last_rd == 61, "R6 read at 61", last_rd, 61);
   endtask

   task automatic t_range_edge();
      do_reset();
      expect_instr("R8 start at 0", l_op(0), l_ad(0));
      finish(1'b1, 999, 1'b1);
      expect_instr("R8 right of last word 999", r_op(999), r_ad(999));
      finish(1'b0, 0, 1'b0);
      repeat (3) @(negedge clk);
      chk(halted == 1'b1, "R8 halt past 999", int'(halted), 1);
      repeat (20) @(negedge clk);
      chk(halted && !mem_req && !exec_valid, "R8 halt sticky and quiet",
          int'(mem_req) + int'(exec_valid), 0);
      chk(last_rd == 999, "R8 no read above 999", last_rd, 999);
   endtask

   task automatic t_range_direct();
      int rc;
      do_reset();
      expect_instr("R8 start at 0 again", l_op(0), l_ad(0));
      rc = rd_count;
      finish(1'b1, 1000, 1'b0);
      repeat (4) @(negedge clk);
      chk(halted == 1'b1, "R8 branch to 1000 halts", int'(halted), 1);
      chk(rd_count == rc, "R8 no read of 1000", rd_count, rc);
      do_reset();
      @(negedge clk);
      chk(!halted && mem_req && mem_addr == 0, "R1 reset clears halt", int'(halted), 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=<50000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_pair_order();
      t_slow_read();
      t_branch();
      t_range_edge();
      t_range_direct();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule